// File: doc/BRIEF.md
# Shared-Memory Slave Access Acknowledge

This block decides when a host may use the local bus of a network controller that is also a bus master. The host raises one of two active-low requests: a register select, which reaches the controller's registers, or a shared-memory request, which reaches buffer memory on the controller's bus. Both requests can change at any time relative to the bus clock. Each one is brought into the clock domain through flops clocked on the falling edge. When the internal master is idle, the block answers on the next rising edge with an active-low acknowledge. When the internal master is in the middle of a cycle, the block first waits for that cycle to end, but never more than a fixed number of clocks.

The cause of the acknowledge sets how long it is held. A memory request keeps the acknowledge low for as long as the request stays asserted, so one grant covers any number of memory accesses. A register select also needs the host's address strobe at its active level. The bus-mode pin picks that level. The acknowledge drops whenever the strobe goes inactive, so it pulses once per register access. While the acknowledge is low, and for one clock after it rises, the internal master's requests are held off. The block also flags a host that breaks the rule that the two requests must be separated by at least two clocks.

Top module: `slv_ack_arb`

## Requirements
- R1: After reset, ack_n is 1 and conflict is 0. With dma_req high, dma_grant is 1 from the first clock after reset.
- R2: Each request passes through SYNC_STAGES (default 2) falling-edge flops. With dma_busy low, a request driven just after rising edge P0 makes ack_n go low after rising edge P2 and not before.
- R3: An acknowledge caused by mreq_n stays low, whatever the address strobe does, until mreq_n is deasserted. A deassertion driven just after edge P leaves ack_n low after P+1 and high after P+2.
- R4: cs_n low with the address strobe inactive never produces an acknowledge.
- R5: The strobe as_in is active low when bus_mode is 1 and active high when bus_mode is 0.
- R6: An acknowledge caused by cs_n rises two edges after the strobe goes inactive. With cs_n still low, it falls again two edges after the strobe becomes active again.
- R7: If dma_busy is high when a request is first seen, the acknowledge is delayed until the first rising edge at which dma_busy is sampled low.
- R8: The wait for the internal master lasts at most REL_MAX (default 4) clocks. With dma_busy stuck high, ack_n falls after edge P2+REL_MAX instead of P2.
- R9: dma_grant is 0 while ack_n is low and for one clock after ack_n rises. After that it follows dma_req again.
- R10: conflict is 1 for one clock, two edges after a request is driven, when the other request was still asserted, or was deasserted less than MIN_GAP (default 2) clocks earlier, measured between driving edges.
- R11: When both requests arrive in the same cycle, the memory request wins, and the acknowledge holds with the strobe inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Register select from host, active low, asynchronous |
| mreq_n | input | 1 | Shared-memory request from host, active low, asynchronous |
| as_in | input | 1 | Host address strobe, polarity set by bus_mode |
| bus_mode | input | 1 | 1: strobe active low; 0: strobe active high |
| dma_busy | input | 1 | Internal master cycle in progress |
| dma_req | input | 1 | Internal master wants the bus |
| ack_n | output | 1 | Slave access acknowledge, active low |
| dma_grant | output | 1 | Internal master may proceed |
| conflict | output | 1 | One-clock pulse on a request spacing violation |

## Verification
The hardest case to reach is the spacing violation: a request that rises exactly one clock after the other was released. That case needs the two synchronizer pipelines to be out of step by exactly one edge, so a late or early flag would go unnoticed in a loose test. The bench drives every input one time unit after a rising edge and counts edges from there. It places the second request one edge and then two edges after the first is dropped, so the flag must appear in the first case and stay clear in the second. The bounded release wait is reached by holding dma_busy high through the whole wait. This shows the cap, and not the end of the busy cycle, is what ends the wait.

// File: rtl/slv_ack_arb.sv
module slv_ack_arb #(
  parameter int SYNC_STAGES = 2,
  parameter int REL_MAX     = 4,
  parameter int MIN_GAP     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic mreq_n,
  input  logic as_in,
  input  logic bus_mode,
  input  logic dma_busy,
  input  logic dma_req,
  output logic ack_n,
  output logic dma_grant,
  output logic conflict
);
  localparam int CW = $clog2(REL_MAX + 1);
  localparam logic [CW-1:0] REL_LAST = CW'(REL_MAX - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_MEM, ST_REG} st_t;

  logic [SYNC_STAGES-1:0] cs_sh, mr_sh, as_sh;
  logic cs_s, mr_s, strb_on, reg_req;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh <= '0;
      mr_sh <= '0;
      as_sh <= '0;
    end else begin
      cs_sh <= {cs_sh[SYNC_STAGES-2:0], ~cs_n};
      mr_sh <= {mr_sh[SYNC_STAGES-2:0], ~mreq_n};
      as_sh <= {as_sh[SYNC_STAGES-2:0], as_in};
    end
  end

  assign cs_s    = cs_sh[SYNC_STAGES-1];
  assign mr_s    = mr_sh[SYNC_STAGES-1];
  assign strb_on = bus_mode ? ~as_sh[SYNC_STAGES-1] : as_sh[SYNC_STAGES-1];
  assign reg_req = cs_s & strb_on;

  logic [MIN_GAP-1:0] cs_hist, mr_hist;
  logic viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hist  <= '0;
      mr_hist  <= '0;
      conflict <= 1'b0;
    end else begin
      cs_hist  <= {cs_hist[MIN_GAP-2:0], cs_s};
      mr_hist  <= {mr_hist[MIN_GAP-2:0], mr_s};
      conflict <= viol;
    end
  end

  assign viol = (mr_s & ~mr_hist[0] & (cs_s | (|cs_hist))) |
                (cs_s & ~cs_hist[0] & (mr_s | (|mr_hist)));

  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic release_ok, ack_on, ack_nx, cool;

  assign release_ok = ~dma_busy | (cnt == REL_LAST);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:
        if (mr_s)         st_nx = dma_busy ? ST_WAIT : ST_MEM;
        else if (reg_req) st_nx = dma_busy ? ST_WAIT : ST_REG;
      ST_WAIT:
        if (!(mr_s | reg_req)) st_nx = ST_IDLE;
        else if (release_ok)   st_nx = mr_s ? ST_MEM : ST_REG;
      ST_MEM:  if (!mr_s)    st_nx = ST_IDLE;
      ST_REG:  if (!reg_req) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign ack_on = (st == ST_MEM) | (st == ST_REG);
  assign ack_nx = (st_nx == ST_MEM) | (st_nx == ST_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      cool <= 1'b0;
    end else begin
      st   <= st_nx;
      cnt  <= (st == ST_WAIT && st_nx == ST_WAIT) ? cnt + 1'b1 : '0;
      cool <= ack_on & ~ack_nx;
    end
  end

  assign ack_n     = ~ack_on;
  assign dma_grant = dma_req & (st == ST_IDLE) & ~cool;

  // R3 R6
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> $past(mr_s | reg_req));

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MEM && mr_s) |=> !ack_n);

  // R9
  grant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !dma_grant);

  // R9
  grant_cool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> !dma_grant);

  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> (cnt <= REL_LAST));

  // R4
  reg_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !mr_s && !strb_on) |=> ack_n);
endmodule

// File: tb/sim_slv_ack_arb.sv
module sim_slv_ack_arb;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, mreq_n = 1, as_in = 1, bus_mode = 1, dma_busy = 0, dma_req = 0;
  logic ack_n, dma_grant, conflict;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slv_ack_arb u0 (.clk, .rst_n, .cs_n, .mreq_n, .as_in, .bus_mode,
                  .dma_busy, .dma_req, .ack_n, .dma_grant, .conflict);

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    dma_req = 1;
    tick();
    chk("R1 ack", ack_n, 1);
    chk("R1 conflict", conflict, 0);
    chk("R1 grant", dma_grant, 1);
    dma_req = 0;
  endtask

  task automatic t_mem();
    dma_req = 1;
    mreq_n = 0;
    tick(); chk("R2 early", ack_n, 1);
    tick(); chk("R2 ack", ack_n, 0);
    chk("R9 blocked", dma_grant, 0);
    for (int i = 0; i < 6; i++) begin
      as_in = ~as_in;
      tick(); chk("R3 hold", ack_n, 0);
    end
    as_in = 1;
    mreq_n = 1;
    tick(); chk("R3 still low", ack_n, 0);
    tick(); chk("R3 release", ack_n, 1);
    chk("R9 cool", dma_grant, 0);
    tick(); chk("R9 resume", dma_grant, 1);
    dma_req = 0;
    tick(4);
  endtask

  task automatic t_reg_mode1();
    bus_mode = 1; as_in = 1;
    cs_n = 0;
    tick(5); chk("R4 no strobe", ack_n, 1);
    as_in = 0;
    tick(); chk("R5 early", ack_n, 1);
    tick(); chk("R5 low strobe", ack_n, 0);
    as_in = 1;
    tick(); chk("R6 still", ack_n, 0);
    tick(); chk("R6 drop", ack_n, 1);
    as_in = 0;
    tick(2); chk("R6 again", ack_n, 0);
    as_in = 1; cs_n = 1;
    tick(5);
  endtask

  task automatic t_reg_mode0();
    bus_mode = 0; as_in = 0;
    cs_n = 0;
    tick(4); chk("R5 mode0 idle", ack_n, 1);
    as_in = 1;
    tick(2); chk("R5 high strobe", ack_n, 0);
    as_in = 0; cs_n = 1;
    tick(5); chk("R6 mode0 drop", ack_n, 1);
    bus_mode = 1; as_in = 1;
    tick(2);
  endtask

  task automatic t_busy_end();
    dma_busy = 1;
    mreq_n = 0;
    tick(3); chk("R7 wait", ack_n, 1);
    dma_busy = 0;
    tick(); chk("R7 release", ack_n, 0);
    mreq_n = 1;
    tick(5);
  endtask

  task automatic t_busy_cap();
    dma_busy = 1;
    mreq_n = 0;
    tick(5); chk("R8 before cap", ack_n, 1);
    tick(); chk("R8 cap", ack_n, 0);
    mreq_n = 1; dma_busy = 0;
    tick(5);
  endtask

  task automatic t_gap(int gap, bit exp_flag);
    bit seen = 0;
    mreq_n = 0;
    tick(3);
    mreq_n = 1;
    tick(gap);
    cs_n = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (conflict) seen = 1;
    end
    chk(exp_flag ? "R10 violation" : "R10 legal gap", seen, exp_flag);
    cs_n = 1;
    tick(5);
  endtask

  task automatic t_both();
    as_in = 1; bus_mode = 1;
    mreq_n = 0; cs_n = 0;
    tick(2); chk("R10 simultaneous", conflict, 1);
    chk("R11 ack", ack_n, 0);
    cs_n = 1;
    tick(4); chk("R11 mem wins", ack_n, 0);
    mreq_n = 1;
    tick(5);
  endtask

  initial begin
    #1;
    tick(2);
    rst_n = 1;
    t_reset();
    tick(3);
    t_mem();
    t_reg_mode1();
    t_reg_mode0();
    t_busy_end();
    t_busy_cap();
    t_gap(1, 1);
    t_gap(2, 0);
    t_both();
    summary();
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end
endmodule